// File: doc/BRIEF.md
# Trap Entry State-Save Controller

This block performs the hardware side of taking a trap on a 64-bit processor with register windows. A trap request carries a 9-bit trap type. On the clock edge that samples the request, the block raises the trap level and saves the old context into a per-level trap-stack entry: a packed state word, the PC, the next PC and the trap type. It also rewrites the processor-state bits and moves the current window pointer when the trap is a window trap. It then redirects the PC to a vector formed from the trap base address, the trap type and a flag for nested traps.

The processor core supplies the condition codes, the address-space identifier, the count of savable windows and the upper bits of the trap base address as inputs. The block owns the trap level, the processor-state word, the window pointer, PC, next PC and the trap stack. When a request arrives while the trap level is already at its maximum, the block takes no trap and raises a sticky error flag. A combinational read port returns any trap-stack entry, so the saved context can be inspected.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, tl_o = 0, pstate_o = 0, cwp_o = 0, pc_o = 0, npc_o = 4, trap_ack = 0, trap_err = 0, and every trap-stack entry reads as all zeros.
- R2: A trap_req sampled while tl_o < MAXTL and trap_err = 0 is taken. On the next cycle trap_ack is 1 for that one cycle and tl_o has risen by exactly one.
- R3: A trap taken from level MAXTL-1 sets the red-state bit (pstate bit 5). Traps taken from lower levels leave that bit unchanged.
- R4: A trap_req sampled while tl_o >= MAXTL (or while trap_err = 1) is not taken. trap_ack stays 0 and tl_o, pstate_o, cwp_o, pc_o and npc_o are unchanged. trap_err becomes 1 on the next cycle and stays 1 until reset.
- R5: The saved state word is 40 bits. Bits 39:32 hold ccr_i, bits 31:24 hold asi_i, bits 19:8 hold the processor state ANDed with 0xF3F, and the low bits hold the old window pointer. All other bits are 0. The processor state saved is the value after any red-state bit of R3 has been set.
- R6: A taken trap writes the saved word, the old PC, the old next PC and the trap type into the stack entry whose index is the new trap level ANDed with the index mask (7 by default). Every other entry is unchanged.
- R7: After a taken trap, the FP-enable bit (4) and the privileged bit (2) are 1, and exactly one global-select bit is 1. Interrupt globals (bit 11) are selected for type 0x060. MMU globals (bit 10) are selected for types 0x008, 0x030 and 0x064 to 0x06F. Alternate globals (bit 0) are selected for every other type. Bits 7:6 and the other bits are kept.
- R8: Type 0x024 sets the window pointer to CWP-1. A type whose value ANDed with 0x1C0 equals 0x080 sets it to CWP-CANSAVE-2. A type whose value ANDed with 0x1C0 equals 0x0C0 sets it to CWP+1. Each result wraps modulo NWINDOWS. All other types keep the window pointer.
- R9: After a taken trap, pc_o = {tba_i, new level > 1, trap type, 5'b00000} and npc_o = pc_o + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled each rising edge |
| trap_type | input | 9 | Trap type of the request |
| ccr_i | input | 8 | Current condition codes |
| asi_i | input | 8 | Current address-space identifier |
| cansave_i | input | $clog2(NWINDOWS) | Number of windows that can be saved |
| tba_i | input | 49 | Trap base address, bits 63:15 |
| trap_ack | output | 1 | One-cycle pulse: trap applied |
| trap_err | output | 1 | Sticky error: trap requested at maximum level |
| tl_o | output | $clog2(MAXTL+1) | Current trap level |
| pstate_o | output | 12 | Processor state word |
| cwp_o | output | $clog2(NWINDOWS) | Current window pointer |
| pc_o | output | 64 | Program counter |
| npc_o | output | 64 | Next program counter |
| rd_lvl | input | $clog2(MAXTL+1) | Trap-stack read index |
| rd_tstate | output | 40 | Saved state word at rd_lvl |
| rd_tpc | output | 64 | Saved PC at rd_lvl |
| rd_tnpc | output | 64 | Saved next PC at rd_lvl |
| rd_tt | output | 9 | Saved trap type at rd_lvl |

## Verification
Two things happen in the same update when a trap is taken from level MAXTL-1: the red-state bit is set and the state word is packed. The saved word must already carry the new bit. The bench reaches this case repeatedly by sweeping all 512 trap types in runs of back-to-back traps, each run starting from reset, so every run climbs the whole level ladder. Each result is compared with a bench model that sets the red bit before it packs the word, and a request at the top level then confirms that the block refuses the trap.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int PS_W      = 12;
    localparam int TT_W      = 9;
    localparam int CCR_W     = 8;
    localparam int ASI_W     = 8;
    localparam int TSTATE_W  = 40;
    localparam int XLEN      = 64;
    localparam int TBA_W     = XLEN - 15;

    // processor-state bit positions
    localparam int PS_ALTG   = 0;
    localparam int PS_PRIV   = 2;
    localparam int PS_FPEN   = 4;
    localparam int PS_RED    = 5;
    localparam int PS_MMUG   = 10;
    localparam int PS_INTG   = 11;

    localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;

    // trap types with fixed decode meaning
    localparam logic [TT_W-1:0] TT_INSN_FAULT = 9'h008;
    localparam logic [TT_W-1:0] TT_CLEANWIN   = 9'h024;
    localparam logic [TT_W-1:0] TT_DATA_FAULT = 9'h030;
    localparam logic [TT_W-1:0] TT_INTVEC     = 9'h060;
    localparam logic [TT_W-1:0] TT_INSN_MISS  = 9'h064;
    localparam logic [TT_W-1:0] TT_DATA_MISS  = 9'h068;
    localparam logic [TT_W-1:0] TT_DATA_PROT  = 9'h06C;
    localparam logic [TT_W-1:0] TT_CLASS_MASK = 9'h1C0;
    localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
    localparam logic [TT_W-1:0] TT_FILL_BASE  = 9'h0C0;

    typedef enum logic [1:0] {
        GSEL_ALT = 2'd0,
        GSEL_MMU = 2'd1,
        GSEL_INT = 2'd2
    } gsel_e;

    typedef enum logic [1:0] {
        WIN_KEEP  = 2'd0,
        WIN_CLEAN = 2'd1,
        WIN_SPILL = 2'd2,
        WIN_FILL  = 2'd3
    } winop_e;

    typedef struct packed {
        logic [TSTATE_W-1:0] tstate;
        logic [XLEN-1:0]     tpc;
        logic [XLEN-1:0]     tnpc;
        logic [TT_W-1:0]     tt;
    } ts_entry_t;

endpackage

// File: rtl/trap_class_decode.sv
module trap_class_decode
    import trap_entry_pkg::*;
(
    input  logic [TT_W-1:0] tt,
    output gsel_e           gsel,
    output winop_e          winop
);
    logic is_mmu;

    always_comb begin
        // four-entry groups share all bits above bit 1
        is_mmu = (tt == TT_INSN_FAULT) || (tt == TT_DATA_FAULT)
              || (tt[TT_W-1:2] == TT_INSN_MISS[TT_W-1:2])
              || (tt[TT_W-1:2] == TT_DATA_MISS[TT_W-1:2])
              || (tt[TT_W-1:2] == TT_DATA_PROT[TT_W-1:2]);

        if (tt == TT_INTVEC)  gsel = GSEL_INT;
        else if (is_mmu)      gsel = GSEL_MMU;
        else                  gsel = GSEL_ALT;

        if (tt == TT_CLEANWIN)                          winop = WIN_CLEAN;
        else if ((tt & TT_CLASS_MASK) == TT_SPILL_BASE) winop = WIN_SPILL;
        else if ((tt & TT_CLASS_MASK) == TT_FILL_BASE)  winop = WIN_FILL;
        else                                            winop = WIN_KEEP;
    end
endmodule

// File: rtl/trap_cwp_adjust.sv
module trap_cwp_adjust
    import trap_entry_pkg::*;
#(
    parameter int NWINDOWS = 8,
    localparam int CW      = $clog2(NWINDOWS)
) (
    input  logic [CW-1:0] cwp,
    input  logic [CW-1:0] cansave,
    input  winop_e        winop,
    output logic [CW-1:0] cwp_new
);
    int unsigned sum;

    always_comb begin
        // offsets of whole multiples of NWINDOWS keep the sum non-negative
        unique case (winop)
            WIN_CLEAN: sum = int'(cwp) + NWINDOWS - 1;
            WIN_SPILL: sum = int'(cwp) + 2 * NWINDOWS - int'(cansave) - 2;
            WIN_FILL:  sum = int'(cwp) + 1;
            default:   sum = int'(cwp);
        endcase
        cwp_new = CW'(sum % NWINDOWS);
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
    import trap_entry_pkg::*;
#(
    parameter int IW    = 3,
    localparam int DEPTH = 1 << IW
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  logic [IW-1:0] wr_idx,
    input  ts_entry_t wr_ent,
    input  logic [IW-1:0] rd_idx,
    output ts_entry_t rd_ent
);
    ts_entry_t ent_view [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        ts_entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (wr_idx == IW'(i))) ent_d = wr_ent;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ent_view[i] = ent_q;
    end

    assign rd_ent = ent_view[rd_idx];
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int MAXTL    = 5,
    parameter int NWINDOWS = 8,
    localparam int TLW     = $clog2(MAXTL + 1),
    localparam int CW      = $clog2(NWINDOWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic [TT_W-1:0]     trap_type,
    input  logic [CCR_W-1:0]    ccr_i,
    input  logic [ASI_W-1:0]    asi_i,
    input  logic [CW-1:0]       cansave_i,
    input  logic [TBA_W-1:0]    tba_i,
    output logic                trap_ack,
    output logic                trap_err,
    output logic [TLW-1:0]      tl_o,
    output logic [PS_W-1:0]     pstate_o,
    output logic [CW-1:0]       cwp_o,
    output logic [XLEN-1:0]     pc_o,
    output logic [XLEN-1:0]     npc_o,
    input  logic [TLW-1:0]      rd_lvl,
    output logic [TSTATE_W-1:0] rd_tstate,
    output logic [XLEN-1:0]     rd_tpc,
    output logic [XLEN-1:0]     rd_tnpc,
    output logic [TT_W-1:0]     rd_tt
);
    localparam int IW = TLW;
    localparam logic [IW-1:0] IDX_MASK = {IW{1'b1}};

    typedef struct packed {
        logic [TLW-1:0]  tl;
        logic [PS_W-1:0] pstate;
        logic [CW-1:0]   cwp;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic            ack;
        logic            err;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    gsel_e           gsel;
    winop_e          winop;
    logic [CW-1:0]   cwp_adj;
    logic            take;
    logic            set_red;
    logic [TLW-1:0]  tl_new;
    logic [PS_W-1:0] ps_mid;
    logic [PS_W-1:0] ps_glob;
    ts_entry_t       wr_ent;
    ts_entry_t       rd_ent;
    logic [IW-1:0]   wr_idx;

    trap_class_decode u_dec (
        .tt    (trap_type),
        .gsel  (gsel),
        .winop (winop)
    );

    trap_cwp_adjust #(.NWINDOWS(NWINDOWS)) u_cwp (
        .cwp     (st_q.cwp),
        .cansave (cansave_i),
        .winop   (winop),
        .cwp_new (cwp_adj)
    );

    always_comb begin
        take    = trap_req && !st_q.err && (int'(st_q.tl) < MAXTL);
        set_red = (int'(st_q.tl) >= MAXTL - 1);
        tl_new  = st_q.tl + TLW'(1);

        ps_mid = st_q.pstate;
        if (set_red) ps_mid[PS_RED] = 1'b1;

        ps_glob = ps_mid;
        ps_glob[PS_FPEN] = 1'b1;
        ps_glob[PS_PRIV] = 1'b1;
        ps_glob[PS_ALTG] = 1'b0;
        ps_glob[PS_MMUG] = 1'b0;
        ps_glob[PS_INTG] = 1'b0;
        unique case (gsel)
            GSEL_INT: ps_glob[PS_INTG] = 1'b1;
            GSEL_MMU: ps_glob[PS_MMUG] = 1'b1;
            default:  ps_glob[PS_ALTG] = 1'b1;
        endcase

        wr_ent.tstate = (TSTATE_W'(ccr_i) << 32)
                      | (TSTATE_W'(asi_i) << 24)
                      | (TSTATE_W'(ps_mid & PS_SAVE_MASK) << 8)
                      | TSTATE_W'(st_q.cwp);
        wr_ent.tpc    = st_q.pc;
        wr_ent.tnpc   = st_q.npc;
        wr_ent.tt     = trap_type;
        wr_idx        = tl_new & IDX_MASK;

        st_d     = st_q;
        st_d.ack = 1'b0;
        if (take) begin
            st_d.tl     = tl_new;
            st_d.pstate = ps_glob;
            st_d.cwp    = cwp_adj;
            st_d.pc     = {tba_i, (int'(tl_new) > 1), trap_type, 5'b00000};
            st_d.npc    = {tba_i, (int'(tl_new) > 1), trap_type, 5'b00100};
            st_d.ack    = 1'b1;
        end else if (trap_req) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.npc <= XLEN'(4);
        end else begin
            st_q <= st_d;
        end
    end

    trap_stack #(.IW(IW)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (take),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent),
        .rd_idx (rd_lvl),
        .rd_ent (rd_ent)
    );

    assign trap_ack  = st_q.ack;
    assign trap_err  = st_q.err;
    assign tl_o      = st_q.tl;
    assign pstate_o  = st_q.pstate;
    assign cwp_o     = st_q.cwp;
    assign pc_o      = st_q.pc;
    assign npc_o     = st_q.npc;
    assign rd_tstate = rd_ent.tstate;
    assign rd_tpc    = rd_ent.tpc;
    assign rd_tnpc   = rd_ent.tnpc;
    assign rd_tt     = rd_ent.tt;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_entry_pkg::*;
#(
    parameter int MAXTL    = 5,
    parameter int NWINDOWS = 8,
    localparam int TLW     = $clog2(MAXTL + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic            trap_ack,
    input logic            trap_err,
    input logic [TLW-1:0]  tl_o,
    input logic [PS_W-1:0] pstate_o,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] npc_o
);
    assert_tl_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ack |-> (tl_o == $past(tl_o) + TLW'(1)));

    assert_refuse_at_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && (int'(tl_o) >= MAXTL)) |=> (!trap_ack && $stable(tl_o) && trap_err));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_err |=> trap_err);

    assert_red_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ack && (int'(tl_o) == MAXTL)) |-> pstate_o[PS_RED]);

    assert_one_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ack |-> ($countones({pstate_o[PS_INTG], pstate_o[PS_MMUG], pstate_o[PS_ALTG]}) == 1
                      && pstate_o[PS_PRIV] && pstate_o[PS_FPEN]));

    assert_npc_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ack |-> (npc_o == pc_o + XLEN'(4)));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.MAXTL(MAXTL), .NWINDOWS(NWINDOWS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_req (trap_req),
    .trap_ack (trap_ack),
    .trap_err (trap_err),
    .tl_o     (tl_o),
    .pstate_o (pstate_o),
    .pc_o     (pc_o),
    .npc_o    (npc_o)
);

// File: tb/tb_trap_entry_ctrl.sv
`timescale 1ns/100ps
module tb_trap_entry_ctrl;
    localparam int MAXTL = 5;
    localparam int NWIN  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [8:0]  trap_type = '0;
    logic [7:0]  ccr_i = '0;
    logic [7:0]  asi_i = '0;
    logic [2:0]  cansave_i = '0;
    logic [48:0] tba_i = '0;
    logic        trap_ack, trap_err;
    logic [2:0]  tl_o;
    logic [11:0] pstate_o;
    logic [2:0]  cwp_o;
    logic [63:0] pc_o, npc_o;
    logic [2:0]  rd_lvl = '0;
    logic [39:0] rd_tstate;
    logic [63:0] rd_tpc, rd_tnpc;
    logic [8:0]  rd_tt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of architectural state
    int          m_tl, m_cwp;
    logic [11:0] m_ps;
    logic [63:0] m_pc, m_npc;
    logic [39:0] m_ts  [8];
    logic [63:0] m_tpc [8];
    logic [63:0] m_tnpc[8];
    logic [8:0]  m_tt  [8];

    always #4 clk = ~clk;

    trap_entry_ctrl #(.MAXTL(MAXTL), .NWINDOWS(NWIN)) dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .ccr_i(ccr_i), .asi_i(asi_i), .cansave_i(cansave_i), .tba_i(tba_i),
        .trap_ack(trap_ack), .trap_err(trap_err), .tl_o(tl_o), .pstate_o(pstate_o),
        .cwp_o(cwp_o), .pc_o(pc_o), .npc_o(npc_o), .rd_lvl(rd_lvl),
        .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
    );

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic chk_stack(string rq);
        for (int i = 0; i < 8; i++) begin
            rd_lvl = 3'(i);
            #0.2;
            chk(rq, 64'(rd_tstate), 64'(m_ts[i]));
            chk(rq, rd_tpc, m_tpc[i]);
            chk(rq, rd_tnpc, m_tnpc[i]);
            chk(rq, 64'(rd_tt), 64'(m_tt[i]));
        end
    endtask

    task automatic chk_arch(string rq);
        chk(rq, 64'(tl_o), 64'(m_tl));
        chk(rq, 64'(pstate_o), 64'(m_ps));
        chk(rq, 64'(cwp_o), 64'(m_cwp));
        chk(rq, pc_o, m_pc);
        chk(rq, npc_o, m_npc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_tl = 0; m_cwp = 0; m_ps = '0; m_pc = 64'd0; m_npc = 64'd4;
        for (int i = 0; i < 8; i++) begin
            m_ts[i] = '0; m_tpc[i] = '0; m_tnpc[i] = '0; m_tt[i] = '0;
        end
        // R1: reset state
        chk("R1", 64'(trap_ack), 64'd0);
        chk("R1", 64'(trap_err), 64'd0);
        chk_arch("R1");
        chk_stack("R1");
    endtask

    task automatic do_trap(int t);
        int          cs, ntl, idx;
        bit          red;
        logic [11:0] ps_mid, glob;
        logic [39:0] ts;
        cs = (t * 5 + 3) % NWIN;
        @(negedge clk);
        trap_type = 9'(t);
        ccr_i     = 8'(t * 7 + 1);
        asi_i     = 8'(t) ^ 8'h5A;
        cansave_i = 3'(cs);
        tba_i     = {9'(t), 40'hA5_C3F0_0F17};
        trap_req  = 1'b1;
        // expected values from the requirements
        red    = (m_tl == MAXTL - 1);
        ntl    = m_tl + 1;
        ps_mid = m_ps | (red ? 12'h020 : 12'h000);
        ts     = (40'(ccr_i) << 32) | (40'(asi_i) << 24)
               | (40'(ps_mid & 12'hF3F) << 8) | 40'(m_cwp);
        if (t == 'h060) glob = 12'h800;
        else if (t == 'h008 || t == 'h030 || (t >= 'h064 && t <= 'h06F)) glob = 12'h400;
        else glob = 12'h001;
        idx = ntl & 7;
        m_ts[idx] = ts; m_tpc[idx] = m_pc; m_tnpc[idx] = m_npc; m_tt[idx] = 9'(t);
        m_ps = (ps_mid & ~12'hC01) | 12'h014 | glob;
        if (t == 'h024)                  m_cwp = (m_cwp + NWIN - 1) % NWIN;
        else if ((t & 'h1C0) == 'h080)   m_cwp = (m_cwp + 2 * NWIN - cs - 2) % NWIN;
        else if ((t & 'h1C0) == 'h0C0)   m_cwp = (m_cwp + 1) % NWIN;
        m_pc  = {tba_i, (ntl > 1) ? 1'b1 : 1'b0, 9'(t), 5'b00000};
        m_npc = m_pc + 64'd4;
        m_tl  = ntl;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R2", 64'(trap_ack), 64'd1);
        chk("R2", 64'(tl_o), 64'(m_tl));
        chk("R3", 64'(pstate_o[5]), 64'(m_ps[5]));
        chk("R7", 64'(pstate_o), 64'(m_ps));
        chk("R8", 64'(cwp_o), 64'(m_cwp));
        chk("R9", pc_o, m_pc);
        chk("R9", npc_o, m_npc);
        rd_lvl = 3'(idx);
        #0.2;
        chk("R5", 64'(rd_tstate), 64'(ts));
        chk_stack("R6");
        @(negedge clk);
        chk("R2", 64'(trap_ack), 64'd0);
    endtask

    task automatic do_refused();
        @(negedge clk);
        trap_type = 9'h041;
        trap_req  = 1'b1;
        @(negedge clk);
        trap_req  = 1'b0;
        chk("R4", 64'(trap_ack), 64'd0);
        chk("R4", 64'(trap_err), 64'd1);
        chk_arch("R4");
        chk_stack("R4");
        @(negedge clk);
        chk("R4", 64'(trap_err), 64'd1);
    endtask

    initial begin
        do_reset();
        for (int t = 0; t < 512; t++) begin
            do_trap(t);
            if (m_tl == MAXTL) begin
                do_refused();
                do_reset();
            end
        end
        // after error, reset restores a usable state
        do_trap(9'h024);
        do_trap(9'h0C5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule